// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Priority Override

This block picks the next owner of a shared system bus. Up to four symmetric agents share the bus fairly under a rotating priority, and one high-priority agent can take the bus ahead of them. Every agent on the bus runs its own identical copy of this logic and feeds it the same sampled inputs, so all copies reach the same decision on the same edge.

The symmetric pointer records the last symmetric agent that won. The next winner is the first requester found after the pointer, in circular order. A priority request takes the bus without touching that pointer, so symmetric arbitration resumes where it stopped. A lock holds the bus with its current owner. A block input stops any new issue. An address-error cancel or a bus-initialisation event returns the pointer to its post-reset value. Every input is sampled on the rising edge, and the decision appears on the outputs after that edge.

Top module: `busarb_top`

## Requirements
- R1: After rst_ni is released, owner_oh_o is all zero and rot_id_o is N_AGENTS-1, which gives agent 0 the highest rotating priority and agent 1 the next.
- R2: With no override active, the new symmetric owner is the first set bit of req_i found by scanning circularly upward from rot_id_o+1. Its bit i of owner_oh_o and of grant_ok_o is set, and rot_id_o becomes i, on the edge after the requests are sampled.
- R3: Out of reset with every symmetric agent requesting, the grants go to agent 0, then agent 1, then agent 2.
- R4: While prio_req_i is sampled high and no lock hold, block or pointer reset applies, the next owner is the priority agent: owner_oh_o bit N_AGENTS is set and grant_ok_o is all zero.
- R5: A priority grant leaves rot_id_o unchanged, and later symmetric arbitration continues from that same value.
- R6: While lock_i is sampled high and owner_oh_o is non-zero, owner_oh_o and rot_id_o hold, whatever the symmetric or priority requests are.
- R7: Once lock_i is sampled low, arbitration resumes on the following edge.
- R8: While block_i is sampled high and no lock hold or pointer reset applies, owner_oh_o becomes zero and rot_id_o holds.
- R9: addr_err_i or bus_init_i sampled high sets rot_id_o to N_AGENTS-1 and owner_oh_o to zero, even during a lock.
- R10: With no request of any kind pending, owner_oh_o becomes zero and rot_id_o stays parked on the last symmetric owner.
- R11: owner_oh_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_AGENTS | Sampled symmetric request lines, bit i = agent i |
| prio_req_i | input | 1 | Priority agent request |
| lock_i | input | 1 | Keeps the bus with the current owner |
| block_i | input | 1 | Stops any new issue while high |
| addr_err_i | input | 1 | Address-error cancel, resets the pointer |
| bus_init_i | input | 1 | Bus initialisation event, resets the pointer |
| owner_oh_o | output | N_AGENTS+1 | One-hot next owner; bit N_AGENTS is the priority agent |
| grant_ok_o | output | N_AGENTS | Per symmetric agent: may start a transaction |
| rot_id_o | output | $clog2(N_AGENTS) | Last symmetric owner (rotating pointer) |

## Verification
Every output is due exactly one rising edge after the inputs that cause it are sampled. No result is combinational. The driver applies each stimulus on a falling edge and pushes the expected owner, grant and pointer into a queue. The monitor pops one item 2 ns after each following rising edge, so each comparison lands in the cycle where the registers change. Directed sequences cover reset order, priority suspension and resumption, lock hold and release, blocking and pointer resets. A random phase then mixes all the inputs together.

// File: rtl/busarb_pkg.sv
`timescale 1ns/1ps
package busarb_pkg;
  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_RESET,
    DEC_HOLD,
    DEC_BLOCK,
    DEC_PRIO,
    DEC_RR
  } dec_e;
endpackage

// File: rtl/busarb_rr_pick.sv
`timescale 1ns/1ps
module busarb_rr_pick #(
  parameter int N_AGENTS = 4,
  localparam int IW = $clog2(N_AGENTS)
) (
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [IW-1:0]       last_i,
  output logic                hit_o,
  output logic [IW-1:0]       win_o
);
  always_comb begin
    int unsigned idx;
    idx   = 0;
    hit_o = |req_i;
    win_o = '0;
    // scan from farthest to nearest so the nearest requester after last wins
    for (int k = N_AGENTS; k >= 1; k--) begin
      idx = (int'(last_i) + k) % N_AGENTS;
      if (req_i[idx]) win_o = IW'(idx);
    end
  end
endmodule

// File: rtl/busarb_decide.sv
`timescale 1ns/1ps
module busarb_decide
  import busarb_pkg::*;
(
  input  logic rst_evt_i,
  input  logic lock_i,
  input  logic owned_i,
  input  logic block_i,
  input  logic prio_req_i,
  input  logic rr_hit_i,
  output dec_e dec_o
);
  always_comb begin
    if (rst_evt_i)              dec_o = DEC_RESET;
    else if (lock_i && owned_i) dec_o = DEC_HOLD;
    else if (block_i)           dec_o = DEC_BLOCK;
    else if (prio_req_i)        dec_o = DEC_PRIO;
    else if (rr_hit_i)          dec_o = DEC_RR;
    else                        dec_o = DEC_IDLE;
  end
endmodule

// File: rtl/busarb_top.sv
`timescale 1ns/1ps
module busarb_top
  import busarb_pkg::*;
#(
  parameter int N_AGENTS = 4,
  localparam int IW = $clog2(N_AGENTS),
  localparam int OW = N_AGENTS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic                prio_req_i,
  input  logic                lock_i,
  input  logic                block_i,
  input  logic                addr_err_i,
  input  logic                bus_init_i,
  output logic [OW-1:0]       owner_oh_o,
  output logic [N_AGENTS-1:0] grant_ok_o,
  output logic [IW-1:0]       rot_id_o
);
  localparam logic [IW-1:0] ROT_INIT = IW'(N_AGENTS - 1);

  initial assert (N_AGENTS == 2 || N_AGENTS == 4)
    else $error("busarb_top: N_AGENTS must be 2 or 4");

  logic [OW-1:0]       own_q, own_d;
  logic [IW-1:0]       rot_q, rot_d;
  logic                rr_hit;
  logic [IW-1:0]       rr_win;
  logic [N_AGENTS-1:0] win_oh;
  logic                rst_evt;
  dec_e                dec;

  assign rst_evt = addr_err_i | bus_init_i;

  busarb_rr_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .req_i  (req_i),
    .last_i (rot_q),
    .hit_o  (rr_hit),
    .win_o  (rr_win)
  );

  busarb_decide u_decide (
    .rst_evt_i  (rst_evt),
    .lock_i     (lock_i),
    .owned_i    (|own_q),
    .block_i    (block_i),
    .prio_req_i (prio_req_i),
    .rr_hit_i   (rr_hit),
    .dec_o      (dec)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_dec
    assign win_oh[g] = (rr_win == IW'(g));
  end

  always_comb begin
    own_d = '0;
    rot_d = rot_q;
    unique case (dec)
      DEC_RESET: rot_d = ROT_INIT;
      DEC_HOLD:  own_d = own_q;
      DEC_PRIO:  own_d = OW'(1) << N_AGENTS;
      DEC_RR: begin
        own_d = {1'b0, win_oh};
        rot_d = rr_win;
      end
      default:   own_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      rot_q <= ROT_INIT;
    end else begin
      own_q <= own_d;
      rot_q <= rot_d;
    end
  end

  assign owner_oh_o = own_q;
  assign grant_ok_o = own_q[N_AGENTS-1:0];
  assign rot_id_o   = rot_q;

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_oh_o));

  p_prio_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_req_i && !rst_evt && !block_i && !(lock_i && |owner_oh_o))
    |=> (owner_oh_o[N_AGENTS] && grant_ok_o == '0));

  p_prio_keeps_rot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_req_i && !rst_evt) |=> $stable(rot_id_o));

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && |owner_oh_o && !rst_evt) |=> ($stable(owner_oh_o) && $stable(rot_id_o)));

  p_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && !rst_evt && !(lock_i && |owner_oh_o))
    |=> (owner_oh_o == '0 && $stable(rot_id_o)));

  p_ptr_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt |=> (rot_id_o == ROT_INIT && owner_oh_o == '0));
endmodule

// File: tb/busarb_top_tb_top.sv
`timescale 1ns/1ps
module busarb_top_tb_top;
  localparam int N  = 4;
  localparam int IW = $clog2(N);
  localparam int OW = N + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          prio_req_i = 1'b0, lock_i = 1'b0, block_i = 1'b0;
  logic          addr_err_i = 1'b0, bus_init_i = 1'b0;
  logic [OW-1:0] owner_oh_o;
  logic [N-1:0]  grant_ok_o;
  logic [IW-1:0] rot_id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [OW-1:0] m_own = '0;
  logic [IW-1:0] m_rot = IW'(N - 1);

  logic [OW-1:0] q_own[$];
  logic [IW-1:0] q_rot[$];
  string         q_tag[$];

  always #4 clk_i = ~clk_i;

  busarb_top #(.N_AGENTS(N)) dut_i (
    .clk_i, .rst_ni, .req_i, .prio_req_i, .lock_i, .block_i,
    .addr_err_i, .bus_init_i, .owner_oh_o, .grant_ok_o, .rot_id_o
  );

  task automatic check(input string tag, input logic [OW-1:0] eo, input logic [IW-1:0] er);
    n_chk++;
    if (owner_oh_o !== eo || grant_ok_o !== eo[N-1:0] || rot_id_o !== er) begin
      n_bad++;
      $display("FAIL %s: owner=%b grant=%b rot=%0d expected owner=%b grant=%b rot=%0d",
               tag, owner_oh_o, grant_ok_o, rot_id_o, eo, eo[N-1:0], er);
    end
  endtask

  // driver: apply on falling edge, model the next state, push expectation
  task automatic drive(input logic [N-1:0] r, input logic p, input logic lk, input logic bl,
                       input logic ae, input logic bi, input string tag);
    @(negedge clk_i);
    req_i = r; prio_req_i = p; lock_i = lk; block_i = bl;
    addr_err_i = ae; bus_init_i = bi;
    if (ae || bi) begin
      m_own = '0; m_rot = IW'(N - 1);
    end else if (lk && m_own != '0) begin
      // held
    end else if (bl) begin
      m_own = '0;
    end else if (p) begin
      m_own = OW'(1) << N;
    end else if (r != '0) begin
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (int'(m_rot) + k) % N;
        if (r[idx]) begin
          m_own = OW'(1) << idx;
          m_rot = IW'(idx);
          break;
        end
      end
    end else begin
      m_own = '0;
    end
    q_own.push_back(m_own);
    q_rot.push_back(m_rot);
    q_tag.push_back(tag);
  endtask

  // monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q_own.size() > 0) check(q_tag.pop_front(), q_own.pop_front(), q_rot.pop_front());
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check("R1 reset state", '0, IW'(N - 1));

    // R3: order out of reset
    drive(4'b1111, 0, 0, 0, 0, 0, "R3 first grant agent0");
    drive(4'b1111, 0, 0, 0, 0, 0, "R3 second grant agent1");
    drive(4'b1111, 0, 0, 0, 0, 0, "R3 third grant agent2");
    // R2: circular scan from pointer 2
    drive(4'b0101, 0, 0, 0, 0, 0, "R2 wrap to agent0");
    drive(4'b0101, 0, 0, 0, 0, 0, "R2 skip to agent2");
    drive(4'b1000, 0, 0, 0, 0, 0, "R2 single requester");
    // R10: parked
    drive(4'b0000, 0, 0, 0, 0, 0, "R10 idle parked");
    drive(4'b0000, 0, 0, 0, 0, 0, "R10 idle stays parked");
    // R4/R5: priority suspends rotation
    drive(4'b1111, 1, 0, 0, 0, 0, "R4 priority wins");
    drive(4'b1111, 1, 0, 0, 0, 0, "R5 pointer unchanged");
    drive(4'b1111, 0, 0, 0, 0, 0, "R5 resume from same pointer");
    // R6/R7: lock hold and release
    drive(4'b0001, 0, 1, 0, 0, 0, "R6 lock on current owner");
    drive(4'b1111, 1, 1, 0, 0, 0, "R6 lock ignores prio and req");
    drive(4'b1111, 0, 1, 1, 0, 0, "R6 lock beats block");
    drive(4'b1111, 0, 0, 0, 0, 0, "R7 lock dropped, rotate");
    drive(4'b0000, 1, 0, 0, 0, 0, "R4 priority owner");
    drive(4'b0000, 0, 1, 0, 0, 0, "R6 lock holds priority owner");
    drive(4'b0000, 0, 0, 0, 0, 0, "R7 released to idle");
    drive(4'b0110, 0, 1, 0, 0, 0, "R7 lock with no owner arbitrates");
    drive(4'b0110, 0, 0, 0, 0, 0, "R2 next requester");
    // R8: block
    drive(4'b1111, 1, 0, 1, 0, 0, "R8 block stops issue");
    drive(4'b1111, 0, 0, 0, 0, 0, "R8 pointer kept across block");
    // R9: pointer reset events
    drive(4'b1111, 0, 1, 0, 1, 0, "R9 addr error during lock");
    drive(4'b1111, 0, 0, 0, 0, 0, "R9 agent0 after addr error");
    drive(4'b1111, 0, 0, 0, 0, 0, "R9 agent1 next");
    drive(4'b0000, 0, 0, 0, 0, 1, "R9 bus init");
    drive(4'b0010, 0, 0, 0, 0, 0, "R9 pointer from init state");

    // mixed random phase, R11 covered by every owner compare
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] r;
      logic p, lk, bl, ae, bi;
      r  = N'($urandom_range(0, (1 << N) - 1));
      p  = ($urandom_range(0, 5) == 0);
      lk = ($urandom_range(0, 3) == 0);
      bl = ($urandom_range(0, 7) == 0);
      ae = ($urandom_range(0, 19) == 0);
      bi = ($urandom_range(0, 29) == 0);
      drive(r, p, lk, bl, ae, bi, "R11 random mix");
    end

    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule